// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer

This block is an 8-bit up-counter driven by a programmable prescaler, together with an 8-bit control register. Software writes either register with a 16-bit word. The upper byte is a key, and the write is dropped unless the key matches the register being written. Software reads either register back as a byte.

When the counter wraps from 0xFF to 0x00, a sticky overflow flag is set. What else happens depends on the mode:
- In watchdog mode, the wrap also produces a single-cycle reset request. A companion output tells the reset generator whether to perform a power-on or a manual reset.
- In interval mode, the wrap raises an interrupt level instead. The interrupt stays high until software clears the flag.

The reset request comes only from the wrap itself. Setting the enable, mode and reset-type bits after an overflow therefore cannot produce a late or spurious reset.

Top module: `kwd_top`

## Requirements
- R1: A write with `wr_sel`=0 loads the counter from `wr_data[7:0]` only when `wr_data[15:8]` is 0x5A.
- R2: A write with `wr_sel`=1 updates the control register only when `wr_data[15:8]` is 0xA5. The control layout is as follows:
  - bit 7: run.
  - bit 6: mode, where 1 means watchdog and 0 means interval.
  - bit 5: reset type, where 1 means manual and 0 means power-on.
  - bit 4: overflow flag.
  - bit 3: always reads 0.
  - bits 2:0: clock select.
- R3: A write whose key byte does not match the selected register leaves both registers unchanged.
- R4: While run is 1, the counter advances once every 32·2^sel clock cycles. Counting starts from the write that sets run, so j cycles after that write the count has grown by floor(j / (32·2^sel)).
- R5: While run is 0, the counter holds its value.
- R6: `rd_data` is registered. It shows the counter when `rd_sel`=0 and the control register when `rd_sel`=1, in both cases as they stood before the capturing edge.
- R7: A wrap from 0xFF to 0x00 sets the overflow flag. A keyed control write with bit 4 at 0 clears the flag. Writing 1 to bit 4 leaves the flag as it is.
- R8: In watchdog mode, a wrap drives `rst_req` high for exactly one cycle, in the cycle after the wrapping edge. During that cycle `rst_type` is 1 for manual reset and 0 for power-on reset.
- R9: In interval mode, `irq` is high from the wrapping edge until the flag is cleared, and no reset is requested. In watchdog mode `irq` stays 0.
- R10: Writing run, mode and reset type all to 1 after an overflow, before the next tick, never produces `rst_req`.
- R11: After reset, the counter and the control register read 0x00, and `rst_req` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Write target: 0 counter, 1 control |
| wr_data | input | 16 | Key byte (upper) and value (lower) |
| rd_sel | input | 1 | Read target: 0 counter, 1 control |
| rd_data | output | 8 | Registered read data |
| rst_req | output | 1 | One-cycle reset request |
| rst_type | output | 1 | Reset kind: 1 manual, 0 power-on |
| irq | output | 1 | Interval interrupt level |

## Verification
The key check is exercised with a table of writes:
- correct keys;
- keys swapped between the two registers;
- a wrong key;
- writes that try to set the overflow flag or the unused bit.

Reading both registers back after each write distinguishes accepted writes from rejected ones.

The counting rate is measured on either side of a tick boundary, which tells a correct divide ratio apart from an off-by-one prescaler. Overflows are then forced in three setups:
- watchdog mode with power-on reset;
- watchdog mode with manual reset;
- interval mode.

These separate request-style outputs from level-style ones. A final pattern sets all three control bits just after an interval overflow, which exposes any reset derived from the stale flag rather than from the wrap itself.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam int CNT_W  = 8;
  localparam int SEL_W  = 3;
  localparam logic [7:0] KEY_CNT = 8'h5A;
  localparam logic [7:0] KEY_CTL = 8'hA5;

  typedef struct packed {
    logic             run;
    logic             wdog;
    logic             manual;
    logic             ovf;
    logic             rsv;
    logic [SEL_W-1:0] sel;
  } ctl_t;
endpackage

// File: rtl/kwd_prescaler.sv
module kwd_prescaler #(
  parameter int BASE_LOG = 5,
  parameter int SEL_W    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int NTAP  = 1 << SEL_W;
  localparam int PRE_W = BASE_LOG + NTAP - 1;

  logic [PRE_W-1:0] pre;
  logic [NTAP-1:0]  tap;

  always_ff @(posedge clk) begin
    if (rst || !en) pre <= '0;
    else            pre <= pre + 1'b1;
  end

  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    assign tap[g] = &pre[BASE_LOG+g-1:0];
  end

  assign tick = en & tap[sel];
endmodule

// File: rtl/kwd_counter.sv
module kwd_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  assign wrap = tick & (&cnt) & ~load;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (tick) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/kwd_top.sv
module kwd_top
  import kwd_pkg::*;
#(
  parameter int BASE_LOG = 5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [15:0] wr_data,
  input  logic        rd_sel,
  output logic [7:0]  rd_data,
  output logic        rst_req,
  output logic        rst_type,
  output logic        irq
);
  ctl_t             ctl_q, ctl_n;
  logic [CNT_W-1:0] cnt_q;
  logic             tick, wrap, cnt_wr, ctl_wr;

  assign cnt_wr = wr_en & ~wr_sel & (wr_data[15:8] == KEY_CNT);
  assign ctl_wr = wr_en &  wr_sel & (wr_data[15:8] == KEY_CTL);

  kwd_prescaler #(.BASE_LOG(BASE_LOG), .SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst(rst), .en(ctl_q.run), .sel(ctl_q.sel), .tick(tick)
  );

  kwd_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .load(cnt_wr),
    .load_val(wr_data[CNT_W-1:0]), .cnt(cnt_q), .wrap(wrap)
  );

  always_comb begin
    ctl_n = ctl_q;
    if (ctl_wr) begin
      ctl_n.run    = wr_data[7];
      ctl_n.wdog   = wr_data[6];
      ctl_n.manual = wr_data[5];
      ctl_n.ovf    = ctl_q.ovf & wr_data[4];
      ctl_n.sel    = wr_data[SEL_W-1:0];
    end
    if (wrap) ctl_n.ovf = 1'b1;
    ctl_n.rsv = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q    <= '0;
      rst_req  <= 1'b0;
      rst_type <= 1'b0;
      irq      <= 1'b0;
      rd_data  <= '0;
    end else begin
      ctl_q    <= ctl_n;
      rst_req  <= wrap & ctl_q.wdog;
      rst_type <= ctl_q.manual;
      irq      <= ctl_n.ovf & ~ctl_n.wdog;
      rd_data  <= rd_sel ? ctl_q : cnt_q;
    end
  end
endmodule

// File: rtl/kwd_checker.sv
module kwd_checker (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic        wr_sel,
  input logic [15:0] wr_data,
  input logic [7:0]  cnt,
  input logic [7:0]  ctl,
  input logic        rst_req,
  input logic        irq
);
  logic cnt_keyed;
  assign cnt_keyed = wr_en && !wr_sel && wr_data[15:8] == 8'h5A;

  // R8: request lasts one cycle
  assert_req_single_R8: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);

  // R8: request only right after the counter wrapped to zero
  assert_req_after_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> cnt == 8'h00);

  // R9: interrupt implies the flag is set
  assert_irq_flag_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> ctl[4]);

  // R3: control fields ignore a wrong key
  assert_ctl_key_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel && wr_data[15:8] != 8'hA5)
      |=> {ctl[7:5], ctl[2:0]} == $past({ctl[7:5], ctl[2:0]}));

  // R5: stopped counter holds unless loaded
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!ctl[7] && !cnt_keyed) |=> cnt == $past(cnt));

  // R2: unused bit reads zero
  assert_rsv_R2: assert property (@(posedge clk) disable iff (rst)
    !ctl[3]);
endmodule

bind kwd_top kwd_checker u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .cnt(cnt_q), .ctl(ctl_q), .rst_req(rst_req), .irq(irq)
);

// File: tb/sim_kwd_top.sv
module sim_kwd_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_sel = 1'b0;
  logic [7:0]  rd_data;
  logic        rst_req, rst_type, irq;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  logic [7:0] v;

  always #10 clk = ~clk;

  kwd_top u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .rst_req(rst_req),
    .rst_type(rst_type), .irq(irq)
  );

  always @(negedge clk) if (!rst && rst_req) pulses++;

  // {sel, data, expected counter, expected control}
  localparam logic [32:0] VEC [8] = '{
    {1'b0, 16'h5A37, 8'h37, 8'h00},
    {1'b0, 16'h5B99, 8'h37, 8'h00},
    {1'b1, 16'hA545, 8'h37, 8'h45},
    {1'b1, 16'h5A2F, 8'h37, 8'h45},
    {1'b0, 16'hA5FF, 8'h37, 8'h45},
    {1'b1, 16'hA538, 8'h37, 8'h20},
    {1'b0, 16'h5A00, 8'h00, 8'h20},
    {1'b1, 16'hA500, 8'h00, 8'h00}
  };

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic sel, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic sel, output logic [7:0] val);
    @(negedge clk);
    rd_sel = sel;
    @(negedge clk);
    val = rd_data;
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    rd(1'b0, v); chk("R11 counter", v, 8'h00);
    rd(1'b1, v); chk("R11 control", v, 8'h00);
    chk("R11 outputs", {rst_req, irq}, 2'b00);

    // R1 R2 R3 R6 key table
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][32], VEC[i][31:16]);
      rd(1'b0, v); chk($sformatf("R1/R3 vec%0d counter", i), v, VEC[i][15:8]);
      rd(1'b1, v); chk($sformatf("R2/R3 vec%0d control", i), v, VEC[i][7:0]);
    end

    // R4 rate with select 1 (64 cycles)
    rd_sel = 1'b0;
    wr(1'b1, 16'hA581);
    repeat (192) @(negedge clk);
    chk("R4 before tick", rd_data, 8'h02);
    @(negedge clk);
    chk("R4 at tick", rd_data, 8'h03);

    // R5 stopped counter holds
    wr(1'b1, 16'hA501);
    repeat (2) @(negedge clk);
    v = rd_data;
    chk("R5 stop value", v, 8'h03);
    repeat (300) @(negedge clk);
    chk("R5 hold", rd_data, v);

    // R8 watchdog, power-on
    wr(1'b0, 16'h5AFE);
    wr(1'b1, 16'hA5C0);
    repeat (63) @(negedge clk);
    chk("R8 no early req", rst_req, 1'b0);
    @(negedge clk);
    chk("R8 req power-on", {rst_req, rst_type}, 2'b10);
    chk("R9 no irq in watchdog", irq, 1'b0);
    @(negedge clk);
    chk("R8 single cycle", rst_req, 1'b0);
    rd(1'b1, v); chk("R7 flag set", v, 8'hD0);

    // R8 watchdog, manual (also R7 clear)
    wr(1'b1, 16'hA560);
    rd(1'b1, v); chk("R7 flag cleared", v, 8'h60);
    wr(1'b0, 16'h5AFE);
    wr(1'b1, 16'hA5E0);
    repeat (64) @(negedge clk);
    chk("R8 req manual", {rst_req, rst_type}, 2'b11);
    @(negedge clk);
    chk("R8 pulse count", pulses, 2);

    // R9 interval mode
    wr(1'b1, 16'hA500);
    wr(1'b0, 16'h5AFF);
    wr(1'b1, 16'hA580);
    repeat (31) @(negedge clk);
    chk("R9 irq before wrap", irq, 1'b0);
    @(negedge clk);
    chk("R9 irq at wrap", irq, 1'b1);
    chk("R9 no req", rst_req, 1'b0);
    wr(1'b1, 16'h5A80);
    chk("R3 wrong key keeps irq", irq, 1'b1);

    // R10 set all three bits just after the overflow
    wr(1'b1, 16'hA5F0);
    repeat (40) @(negedge clk);
    chk("R10 no spurious req", pulses, 2);
    rd(1'b1, v); chk("R7 flag kept by 1", v, 8'hF0);
    chk("R9 irq off in watchdog", irq, 1'b0);
    wr(1'b1, 16'hA500);
    rd(1'b1, v); chk("R7 final clear", v, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule